// File: doc/BRIEF.md
# Banked Memory Segment Mapper

This block turns a 16-bit CPU address into a location in a larger paged RAM built from 16 KB banks. The CPU address space is cut into four 16 KB segments, picked by the top two address bits. Each segment owns a bank register that the CPU loads with an I/O write. The value written selects either one bank for both reads and writes (unified mode) or a pair of banks, one for reads and one for writes (split mode).

A separate force register can send the reads of a chosen segment to that segment's write bank. This lets software read back what it has just written without reloading the bank register. For every access the block presents the physical bank number and the 14-bit in-bank offset. Its control and status pins are plain level signals. The only flow is the combinational mapping of the current access, so no valid/ready handshake applies and there is no back-pressure.

Top module: `banked_segment_mapper`

## Requirements
- R1: After reset every segment maps both reads and writes to bank 0, and no segment has its reads forced.
- R2: Address bits 15:14 pick the segment. The I/O port at `BANK_PORT_BASE + k` (0xF0 to 0xF3 by default) loads the register of segment k.
- R3: A bank-register value with bit 7 set selects unified mode. Bits 6:0 give one bank number (0 to 127) that is used for both reads and writes in that segment.
- R4: A bank-register value with bit 7 clear selects split mode. Bits 2:0 give the write bank and bits 6:4 give the read bank, both zero-extended. Bit 3 has no effect.
- R5: A write to the force port (0xF4 by default) loads the read-force bits. Data bit 7 forces segment 3, bit 6 forces segment 0, bit 5 forces segment 2 and bit 4 forces segment 1. A forced segment reads from its write bank. Data bits 3:0 have no effect.
- R6: `map_offset` equals CPU address bits 13:0 for every access.
- R7: An I/O write is taken at the rising clock edge while `io_wr` is high. During that cycle the output still shows the old mapping, and the new mapping appears from the following cycle.
- R8: I/O writes to any port other than the four bank ports and the force port leave every mapping unchanged.
- R9: `map_active` is high when `mem_rd` or `mem_wr` is high. When `mem_wr` is high (including when `mem_rd` is also high), `map_bank` is the write bank and `map_is_write` is 1. Otherwise `map_bank` is the read bank after any force, and `map_is_write` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU memory address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_wr | input | 1 | I/O write cycle strobe |
| io_port | input | 8 | I/O port number |
| io_data | input | 8 | I/O write data |
| map_bank | output | 7 | Physical bank number for the current access |
| map_offset | output | 14 | Offset inside the bank |
| map_active | output | 1 | A memory access is in progress |
| map_is_write | output | 1 | The current access uses the write bank |

## Verification
On every cycle, the bound checker verifies three things:
- A unified or split write to a segment port shows up as the expected bank in the following cycle.
- A read in a split segment goes to the read field unless a shadow of the force register marks that segment as forced.
- The mapped bank does not change while the address, the strobes and the registers are all unchanged.

Some behaviours need a chain of register writes, so only the bench's scenarios show them:
- the cross-wired order of the force bits
- bit 3 and the force low nibble being ignored
- foreign ports being ignored
- a read and a write in the same cycle resolving to the write bank

// File: rtl/segmap_pkg.sv
package segmap_pkg;

  // Per-segment decoded bank selection
  typedef struct packed {
    logic [6:0] rd_bank;
    logic [6:0] wr_bank;
  } seg_sel_t;

  // Position of a segment's read-force bit inside the force-port data byte.
  // The order is fixed by software that already writes this port.
  function automatic int force_bit_of(input int seg);
    case (seg)
      0:       force_bit_of = 6;
      1:       force_bit_of = 4;
      2:       force_bit_of = 5;
      default: force_bit_of = 7;
    endcase
  endfunction

endpackage

// File: rtl/segmap_io_decode.sv
module segmap_io_decode #(
  parameter int          PORT_W         = 8,
  parameter int          SEGS           = 4,
  parameter logic [7:0]  BANK_PORT_BASE = 8'hF0,
  parameter logic [7:0]  FORCE_PORT     = 8'hF4
) (
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  output logic [SEGS-1:0]   seg_we,
  output logic              force_we
);
  for (genvar s = 0; s < SEGS; s++) begin : g_dec
    localparam logic [PORT_W-1:0] MY_PORT = PORT_W'(BANK_PORT_BASE + s);
    assign seg_we[s] = io_wr && (io_port == MY_PORT);
  end

  assign force_we = io_wr && (io_port == PORT_W'(FORCE_PORT));
endmodule

// File: rtl/segmap_seg_reg.sv
module segmap_seg_reg
  import segmap_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BANK_W  = 7,
  parameter int SPLIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] data,
  output seg_sel_t          sel
);
  localparam int MODE_BIT = DATA_W - 1;
  localparam int RD_LSB   = DATA_W / 2;

  seg_sel_t nxt;

  always_comb begin
    if (data[MODE_BIT]) begin
      nxt.rd_bank = data[BANK_W-1:0];
      nxt.wr_bank = data[BANK_W-1:0];
    end else begin
      nxt.rd_bank = BANK_W'(data[RD_LSB +: SPLIT_W]);
      nxt.wr_bank = BANK_W'(data[SPLIT_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  sel <= '0;
    else if (we) sel <= nxt;
  end
endmodule

// File: rtl/segmap_force_reg.sv
module segmap_force_reg
  import segmap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEGS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] data,
  output logic [SEGS-1:0]   force_rd
);
  logic [SEGS-1:0] nxt;

  for (genvar s = 0; s < SEGS; s++) begin : g_map
    assign nxt[s] = data[force_bit_of(s)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  force_rd <= '0;
    else if (we) force_rd <= nxt;
  end
endmodule

// File: rtl/segmap_bank_select.sv
module segmap_bank_select
  import segmap_pkg::*;
#(
  parameter int SEGS   = 4,
  parameter int SEG_W  = 2,
  parameter int BANK_W = 7
) (
  input  seg_sel_t              sel [SEGS],
  input  logic [SEGS-1:0]       force_rd,
  input  logic [SEG_W-1:0]      seg,
  input  logic                  use_wr,
  output logic [BANK_W-1:0]     bank
);
  seg_sel_t cur;
  logic     cur_force;

  always_comb begin
    cur       = sel[seg];
    cur_force = force_rd[seg];
    if (use_wr || cur_force) bank = cur.wr_bank;
    else                     bank = cur.rd_bank;
  end
endmodule

// File: rtl/banked_segment_mapper.sv
module banked_segment_mapper
  import segmap_pkg::*;
#(
  parameter int         ADDR_W         = 16,
  parameter int         SEG_W          = 2,
  parameter int         PORT_W         = 8,
  parameter int         DATA_W         = 8,
  parameter int         BANK_W         = 7,
  parameter int         SPLIT_W        = 3,
  parameter logic [7:0] BANK_PORT_BASE = 8'hF0,
  parameter logic [7:0] FORCE_PORT     = 8'hF4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic                      mem_rd,
  input  logic                      mem_wr,
  input  logic                      io_wr,
  input  logic [PORT_W-1:0]         io_port,
  input  logic [DATA_W-1:0]         io_data,
  output logic [BANK_W-1:0]         map_bank,
  output logic [ADDR_W-SEG_W-1:0]   map_offset,
  output logic                      map_active,
  output logic                      map_is_write
);
  localparam int SEGS  = 1 << SEG_W;
  localparam int OFF_W = ADDR_W - SEG_W;

  logic [SEGS-1:0] seg_we;
  logic            force_we;
  logic [SEGS-1:0] force_rd;
  seg_sel_t        sel [SEGS];

  segmap_io_decode #(
    .PORT_W(PORT_W), .SEGS(SEGS),
    .BANK_PORT_BASE(BANK_PORT_BASE), .FORCE_PORT(FORCE_PORT)
  ) u_dec (
    .io_wr(io_wr), .io_port(io_port), .seg_we(seg_we), .force_we(force_we)
  );

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    segmap_seg_reg #(.DATA_W(DATA_W), .BANK_W(BANK_W), .SPLIT_W(SPLIT_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .we(seg_we[s]), .data(io_data), .sel(sel[s])
    );
  end

  segmap_force_reg #(.DATA_W(DATA_W), .SEGS(SEGS)) u_force (
    .clk(clk), .rst_n(rst_n), .we(force_we), .data(io_data), .force_rd(force_rd)
  );

  segmap_bank_select #(.SEGS(SEGS), .SEG_W(SEG_W), .BANK_W(BANK_W)) u_sel (
    .sel(sel), .force_rd(force_rd), .seg(cpu_addr[ADDR_W-1 -: SEG_W]),
    .use_wr(mem_wr), .bank(map_bank)
  );

  assign map_offset   = cpu_addr[OFF_W-1:0];
  assign map_active   = mem_rd | mem_wr;
  assign map_is_write = mem_wr;
endmodule

// File: rtl/segmap_checker.sv
module segmap_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        io_wr,
  input logic [7:0]  io_port,
  input logic [7:0]  io_data,
  input logic [6:0]  map_bank
);
  // Shadow of the force bits in segment order, built from port activity only
  logic [3:0] shadow_force;
  always_ff @(posedge clk) begin
    if (!rst_n) shadow_force <= '0;
    else if (io_wr && io_port == 8'hF4)
      shadow_force <= {io_data[7], io_data[5], io_data[4], io_data[6]};
  end

  logic hit_seg;
  assign hit_seg = io_wr && io_port[7:2] == 6'b111100;

  // R3
  unified_write_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hit_seg) && $past(io_data[7]) && mem_wr &&
     cpu_addr[15:14] == $past(io_port[1:0]))
    |-> map_bank == $past(io_data[6:0]));

  // R4
  split_write_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hit_seg) && !$past(io_data[7]) && mem_wr &&
     cpu_addr[15:14] == $past(io_port[1:0]))
    |-> map_bank == {4'b0, $past(io_data[2:0])});

  // R5
  split_read_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hit_seg) && !$past(io_data[7]) && mem_rd && !mem_wr &&
     cpu_addr[15:14] == $past(io_port[1:0]))
    |-> map_bank == (shadow_force[cpu_addr[15:14]] ? {4'b0, $past(io_data[2:0])}
                                                   : {4'b0, $past(io_data[6:4])}));

  // R7
  stable_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(io_wr) && $stable(cpu_addr) && $stable(mem_wr))
    |-> $stable(map_bank));
endmodule

bind banked_segment_mapper segmap_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_wr(io_wr), .io_port(io_port), .io_data(io_data), .map_bank(map_bank)
);

// File: tb/banked_segment_mapper_test.sv
module banked_segment_mapper_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic        mem_rd = 0, mem_wr = 0, io_wr = 0;
  logic [7:0]  io_port = 0, io_data = 0;
  logic [6:0]  map_bank;
  logic [13:0] map_offset;
  logic        map_active, map_is_write;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_segment_mapper uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_wr(io_wr), .io_port(io_port), .io_data(io_data), .map_bank(map_bank),
    .map_offset(map_offset), .map_active(map_active), .map_is_write(map_is_write)
  );

  // {port, data, addr, rd, wr, pad, expected bank}
  localparam logic [41:0] VEC [NVEC] = '{
    {8'hF1, 8'h85, 16'h4123, 1'b1, 1'b0, 1'b0, 7'd5},   // R3 unified, R2
    {8'hF1, 8'h85, 16'h4000, 1'b0, 1'b1, 1'b0, 7'd5},   // R3
    {8'hF0, 8'h3A, 16'h0010, 1'b1, 1'b0, 1'b0, 7'd3},   // R4 split read
    {8'hF0, 8'h3A, 16'h3FFF, 1'b0, 1'b1, 1'b0, 7'd2},   // R4 split write
    {8'hF2, 8'hFF, 16'h8000, 1'b1, 1'b0, 1'b0, 7'd127}, // R3 top bank
    {8'hF3, 8'h87, 16'hC001, 1'b0, 1'b1, 1'b0, 7'd7},   // R2 seg3
    {8'hF3, 8'h0C, 16'hFFFF, 1'b0, 1'b1, 1'b0, 7'd4},   // R4 bit3 ignored
    {8'hF3, 8'h0C, 16'hFFFF, 1'b1, 1'b0, 1'b0, 7'd0},   // R4
    {8'hF4, 8'h80, 16'hC000, 1'b1, 1'b0, 1'b0, 7'd4},   // R5 bit7 seg3
    {8'hF4, 8'h40, 16'h0000, 1'b1, 1'b0, 1'b0, 7'd2},   // R5 bit6 seg0
    {8'hF4, 8'h40, 16'hC000, 1'b1, 1'b0, 1'b0, 7'd0},   // R5 seg3 released
    {8'hF2, 8'h61, 16'h8000, 1'b1, 1'b0, 1'b0, 7'd6},   // R4
    {8'hF4, 8'h20, 16'h8000, 1'b1, 1'b0, 1'b0, 7'd1},   // R5 bit5 seg2
    {8'hF1, 8'h47, 16'h4000, 1'b1, 1'b0, 1'b0, 7'd4},   // R4
    {8'hF4, 8'h1F, 16'h4000, 1'b1, 1'b0, 1'b0, 7'd7},   // R5 bit4 seg1, low nibble ignored
    {8'h55, 8'h80, 16'h4000, 1'b1, 1'b0, 1'b0, 7'd7},   // R8 foreign port
    {8'hF5, 8'h80, 16'h0000, 1'b1, 1'b0, 1'b0, 7'd3}    // R8 neighbour port
  };

  task automatic check(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] p, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1; io_port = p; io_data = d;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic access(input string req, input logic [15:0] a, input logic rd,
                        input logic wr, input int exp_bank);
    cpu_addr = a; mem_rd = rd; mem_wr = wr;
    #1;
    check(req, map_bank, exp_bank);
    check({req, " offset R6"}, map_offset, a[13:0]);
    check({req, " active R9"}, map_active, rd | wr);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    for (int s = 0; s < 4; s++) begin
      access("R1 reset read", 16'(s << 14) | 16'h0100, 1, 0, 0);
      access("R1 reset write", 16'(s << 14) | 16'h0200, 0, 1, 0);
    end

    for (int i = 0; i < NVEC; i++) begin
      io_write(VEC[i][41:34], VEC[i][33:26]);
      access($sformatf("vector %0d", i), VEC[i][25:10], VEC[i][9], VEC[i][8],
             int'(VEC[i][6:0]));
    end

    // R9: both strobes pick the write bank (seg0 split: read 3, write 2)
    access("R9 rd+wr", 16'h0005, 1, 1, 2);
    check("R9 is_write", map_is_write, 1);
    access("R9 idle", 16'h0005, 0, 0, 3);
    check("R9 idle is_write", map_is_write, 0);

    // R7: old mapping during the write cycle, new one after the edge
    @(negedge clk);
    cpu_addr = 16'h0000; mem_wr = 1; mem_rd = 0;
    io_wr = 1; io_port = 8'hF0; io_data = 8'h81;
    #1;
    check("R7 before edge", map_bank, 2);
    @(negedge clk);
    io_wr = 0;
    #1;
    check("R7 after edge", map_bank, 1);

    // R1: reset again restores bank 0 and clears force
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    access("R1 re-reset seg1", 16'h4000, 1, 0, 0);
    access("R1 re-reset seg3", 16'hC000, 0, 1, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule